// File: doc/BRIEF.md
# Data Packet Framer and Checker

This block frames and checks data packets on a 16-bit link word path that carries one word per cycle at 125 MHz. The transmit half takes a request that names the payload length in bytes, pulls the payload words from a valid/ready stream, and sends a start word, the payload, a 16-bit CRC and an end word. A request whose length the frame format cannot carry is refused. The refusal is signalled and nothing goes out on the link.

The receive half hunts for a start word and then collects words until an end word arrives. Payload words are streamed out one word late, which lets the last word before the end word be treated as the CRC and kept back. At the end word the block gives a one-cycle completion pulse with separate CRC and length verdicts. Data packets carry detection only: a bad packet is flagged and left to the consumer, and no retransmission exists. Both halves mark link words with a qualifier, so cycles without a frame word are explicit and are not sent as idle codes.

Top module: `pktFramerTop`

## Requirements
- R1: While reset is asserted and after it is released, txReady, linkTxValid, rxValid and rxDone are all 0 until stimulus arrives.
- R2: A transmitted frame is the start code 16'hC5A7, then the payload words in the order they were accepted, then the CRC, then the end code 16'h3A58, each marked by linkTxValid high. When the source keeps txValid high, the whole frame occupies consecutive cycles.
- R3: The transmitted CRC is CRC-16 with polynomial 0x1021 and seed 0xFFFF, no final inversion, run over the payload words only, each word fed most significant bit first.
- R4: txReady is high only while payload words are being taken. With a source that never pauses, it is high for exactly as many cycles as the packet has payload words.
- R5: A request whose txLenBytes is odd, below 8 or above 64 raises txReject in the same cycle with txReady low, takes no word, and produces no link word.
- R6: A pause of the source within the payload inserts a cycle with linkTxValid low into the frame and loses no word.
- R7: On receive, the payload words between the start word and the end word come out on rxData with rxValid, in order. The start word, the end word and the final (CRC) word are not output. rxDone is a one-cycle pulse one cycle after the end word.
- R8: rxCrcOk, valid with rxDone, is 1 exactly when the CRC over the received payload matches the word received before the end word.
- R9: rxLenOk, valid with rxDone, is 1 exactly when the payload held 4 to 32 words (8 to 64 bytes). Frames that are shorter or arbitrarily longer give 0.
- R10: Words received while no frame is open, and any word with linkRxValid low, are ignored. A start word inside an open frame discards that frame without rxDone and opens a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rstN | input | 1 | Active-low synchronous reset |
| txValid | input | 1 | Source offers a request or payload word |
| txReady | output | 1 | Payload word is taken this cycle |
| txData | input | 16 | Payload word from the source |
| txLenBytes | input | 7 | Payload length in bytes, read when a request is offered to an idle framer |
| txReject | output | 1 | Offered request has an unusable length and is refused |
| linkTxData | output | 16 | Outgoing link word |
| linkTxValid | output | 1 | Outgoing link word is part of a frame |
| linkRxData | input | 16 | Incoming link word |
| linkRxValid | input | 1 | Incoming link word is present |
| rxData | output | 16 | Received payload word |
| rxValid | output | 1 | rxData holds a payload word |
| rxDone | output | 1 | End of a received frame, one cycle |
| rxCrcOk | output | 1 | CRC verdict, valid with rxDone |
| rxLenOk | output | 1 | Length verdict, valid with rxDone |

## Verification
The embedded checks assume two things. Payload words and CRC words never equal either control code. A source offering a request holds txData, txLenBytes and txValid steady until the word is taken or the request is refused. The bench builds every payload with a generator that steers away from the two codes. When a computed CRC collides with a code, it changes the first word and computes again. Every source transaction comes from one task that changes inputs only after a clock edge that completed a transfer or a refusal.

// File: rtl/framerPkg.sv
package framerPkg;

  localparam int WORD_W = 16;

  typedef struct packed {
    logic sendStart;
    logic sendPay;
    logic sendCrc;
    logic sendEnd;
  } txStrobeT;

  typedef struct packed {
    logic frameStart;
    logic dataWord;
    logic frameEnd;
  } rxStrobeT;

  // One 16-bit word through the CRC, most significant bit first.
  function automatic logic [WORD_W-1:0] crcNext(
    input logic [WORD_W-1:0] crcIn,
    input logic [WORD_W-1:0] word,
    input logic [WORD_W-1:0] poly
  );
    logic [WORD_W-1:0] acc;
    logic fb;
    acc = crcIn;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      fb  = acc[WORD_W-1] ^ word[b];
      acc = {acc[WORD_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return acc;
  endfunction

endpackage

// File: rtl/txCtrl.sv
module txCtrl
  import framerPkg::*;
#(
  parameter int MIN_BYTES = 8,
  parameter int MAX_BYTES = 64,
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int MAX_WORDS = MAX_BYTES / 2,
  localparam int CNT_W = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txValid,
  input  logic [LEN_W-1:0] txLenBytes,
  output logic             txReady,
  output logic             txReject,
  output txStrobeT         strb
);

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_PAY,
    TX_CRC,
    TX_END
  } txStateT;

  txStateT state;
  logic [CNT_W-1:0] wordsLeft;
  logic lenGood;

  assign lenGood = !txLenBytes[0]
                && (int'(txLenBytes) >= MIN_BYTES)
                && (int'(txLenBytes) <= MAX_BYTES);

  always_comb begin
    strb     = '0;
    txReady  = 1'b0;
    txReject = 1'b0;
    unique case (state)
      TX_IDLE:  txReject = txValid && !lenGood;
      TX_START: strb.sendStart = 1'b1;
      TX_PAY: begin
        txReady      = 1'b1;
        strb.sendPay = txValid;
      end
      TX_CRC:   strb.sendCrc = 1'b1;
      TX_END:   strb.sendEnd = 1'b1;
      default:  strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= TX_IDLE;
      wordsLeft <= '0;
    end else begin
      unique case (state)
        TX_IDLE: begin
          if (txValid && lenGood) begin
            wordsLeft <= CNT_W'(txLenBytes >> 1);
            state     <= TX_START;
          end
        end
        TX_START: state <= TX_PAY;
        TX_PAY: begin
          if (txValid) begin
            wordsLeft <= wordsLeft - CNT_W'(1);
            if (wordsLeft == CNT_W'(1)) state <= TX_CRC;
          end
        end
        TX_CRC:  state <= TX_END;
        TX_END:  state <= TX_IDLE;
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R4: while payload is taken, a word is always still owed and never more than the maximum
  a_r4_words_owed: assert property (@(posedge clk) disable iff (!rstN)
    (state == TX_PAY) |-> (wordsLeft != '0 && int'(wordsLeft) <= MAX_WORDS));

  // R5: a refused request leaves the framer idle, so nothing is taken next cycle
  a_r5_reject_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    txReject |=> !txReady);

endmodule

// File: rtl/txPath.sv
module txPath
  import framerPkg::*;
#(
  parameter logic [WORD_W-1:0] SOP_CODE = 16'hC5A7,
  parameter logic [WORD_W-1:0] EOP_CODE = 16'h3A58,
  parameter logic [WORD_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [WORD_W-1:0] CRC_SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobeT          strb,
  input  logic [WORD_W-1:0] txData,
  output logic [WORD_W-1:0] linkTxData,
  output logic              linkTxValid
);

  logic [WORD_W-1:0] crcReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= CRC_SEED;
    end else if (strb.sendStart) begin
      crcReg <= CRC_SEED;
    end else if (strb.sendPay) begin
      crcReg <= crcNext(crcReg, txData, CRC_POLY);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkTxValid <= 1'b0;
      linkTxData  <= '0;
    end else begin
      linkTxValid <= |strb;
      if (strb.sendStart)    linkTxData <= SOP_CODE;
      else if (strb.sendPay) linkTxData <= txData;
      else if (strb.sendCrc) linkTxData <= crcReg;
      else if (strb.sendEnd) linkTxData <= EOP_CODE;
    end
  end

  // R2: the control never asks for two link words in one cycle
  a_r2_single_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R3: the CRC word is sent only after a start word seeded the register and payload ran through it
  a_r3_crc_after_payload: assert property (@(posedge clk) disable iff (!rstN)
    strb.sendCrc |-> $past(strb.sendPay) || !$past(rstN) || $past(strb.sendPay, 1) == 1'b1);

endmodule

// File: rtl/rxCtrl.sv
module rxCtrl
  import framerPkg::*;
#(
  parameter int MIN_BYTES = 8,
  parameter int MAX_BYTES = 64,
  parameter logic [WORD_W-1:0] SOP_CODE = 16'hC5A7,
  parameter logic [WORD_W-1:0] EOP_CODE = 16'h3A58,
  localparam int MIN_WORDS = MIN_BYTES / 2,
  localparam int MAX_WORDS = MAX_BYTES / 2,
  localparam int SAT_CNT = MAX_WORDS + 2,
  localparam int CNT_W = $clog2(SAT_CNT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] linkRxData,
  input  logic              linkRxValid,
  output rxStrobeT          strb,
  output logic              rxDone,
  output logic              rxLenOk
);

  typedef enum logic {
    RX_HUNT,
    RX_BODY
  } rxStateT;

  rxStateT state;
  logic [CNT_W-1:0] dataCnt;
  logic isSop;
  logic isEop;
  logic inBody;

  assign isSop  = linkRxValid && (linkRxData == SOP_CODE);
  assign isEop  = linkRxValid && (linkRxData == EOP_CODE);
  assign inBody = (state == RX_BODY);

  always_comb begin
    strb            = '0;
    strb.frameStart = isSop;
    strb.dataWord   = inBody && linkRxValid && !isSop && !isEop;
    strb.frameEnd   = inBody && isEop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RX_HUNT;
      dataCnt <= '0;
      rxDone  <= 1'b0;
      rxLenOk <= 1'b0;
    end else begin
      rxDone <= 1'b0;
      if (strb.frameStart) begin
        state   <= RX_BODY;
        dataCnt <= '0;
      end else if (strb.dataWord) begin
        if (int'(dataCnt) != SAT_CNT) dataCnt <= dataCnt + CNT_W'(1);
      end else if (strb.frameEnd) begin
        state   <= RX_HUNT;
        rxDone  <= 1'b1;
        // data words include the trailing CRC word
        rxLenOk <= (int'(dataCnt) >= MIN_WORDS + 1) && (int'(dataCnt) <= MAX_WORDS + 1);
      end
    end
  end

  // R9: the word counter saturates instead of wrapping
  a_r9_count_saturates: assert property (@(posedge clk) disable iff (!rstN)
    int'(dataCnt) <= SAT_CNT);

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

endmodule

// File: rtl/rxPath.sv
module rxPath
  import framerPkg::*;
#(
  parameter logic [WORD_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [WORD_W-1:0] CRC_SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobeT          strb,
  input  logic [WORD_W-1:0] linkRxData,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxCrcOk
);

  logic [WORD_W-1:0] crcReg;
  logic [WORD_W-1:0] holdWord;
  logic              holdValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= CRC_SEED;
      holdWord  <= '0;
      holdValid <= 1'b0;
      rxData    <= '0;
      rxValid   <= 1'b0;
      rxCrcOk   <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.frameStart) begin
        crcReg    <= CRC_SEED;
        holdValid <= 1'b0;
      end else if (strb.dataWord) begin
        // running CRC over payload and CRC word: a clean frame leaves zero
        crcReg    <= crcNext(crcReg, linkRxData, CRC_POLY);
        holdWord  <= linkRxData;
        holdValid <= 1'b1;
        if (holdValid) begin
          rxData  <= holdWord;
          rxValid <= 1'b1;
        end
      end else if (strb.frameEnd) begin
        rxCrcOk   <= (crcReg == '0);
        holdValid <= 1'b0;
      end
    end
  end

  // R10: the control never reports two framing events for one link word
  a_r10_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R7: a payload word is only released while a frame is open
  a_r7_release_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(strb.dataWord));

endmodule

// File: rtl/pktFramerTop.sv
module pktFramerTop
  import framerPkg::*;
#(
  parameter int MIN_BYTES = 8,
  parameter int MAX_BYTES = 64,
  parameter logic [15:0] SOP_CODE = 16'hC5A7,
  parameter logic [15:0] EOP_CODE = 16'h3A58,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_SEED = 16'hFFFF,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txValid,
  output logic             txReady,
  input  logic [15:0]      txData,
  input  logic [LEN_W-1:0] txLenBytes,
  output logic             txReject,
  output logic [15:0]      linkTxData,
  output logic             linkTxValid,
  input  logic [15:0]      linkRxData,
  input  logic             linkRxValid,
  output logic [15:0]      rxData,
  output logic             rxValid,
  output logic             rxDone,
  output logic             rxCrcOk,
  output logic             rxLenOk
);

  txStrobeT txStrb;
  rxStrobeT rxStrb;

  txCtrl #(.MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES)) uTxCtrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txLenBytes(txLenBytes),
    .txReady(txReady), .txReject(txReject), .strb(txStrb)
  );

  txPath #(.SOP_CODE(SOP_CODE), .EOP_CODE(EOP_CODE),
           .CRC_POLY(CRC_POLY), .CRC_SEED(CRC_SEED)) uTxPath (
    .clk(clk), .rstN(rstN), .strb(txStrb), .txData(txData),
    .linkTxData(linkTxData), .linkTxValid(linkTxValid)
  );

  rxCtrl #(.MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES),
           .SOP_CODE(SOP_CODE), .EOP_CODE(EOP_CODE)) uRxCtrl (
    .clk(clk), .rstN(rstN), .linkRxData(linkRxData), .linkRxValid(linkRxValid),
    .strb(rxStrb), .rxDone(rxDone), .rxLenOk(rxLenOk)
  );

  rxPath #(.CRC_POLY(CRC_POLY), .CRC_SEED(CRC_SEED)) uRxPath (
    .clk(clk), .rstN(rstN), .strb(rxStrb), .linkRxData(linkRxData),
    .rxData(rxData), .rxValid(rxValid), .rxCrcOk(rxCrcOk)
  );

  // R2: a payload word taken from the source is on the link in the next cycle
  a_r2_accept_emits: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> linkTxValid);

  // R5: a refused request puts nothing on the link
  a_r5_reject_silent: assert property (@(posedge clk) disable iff (!rstN)
    txReject |=> !linkTxValid);

  // R7: a payload release and a completion never share a cycle
  a_r7_done_apart: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && rxDone));

endmodule

// File: tb/tb_pktFramerTop.sv
module tb_pktFramerTop;

  localparam logic [15:0] SOP = 16'hC5A7;
  localparam logic [15:0] EOP = 16'h3A58;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txValid = 1'b0;
  logic [15:0] txData = '0;
  logic [6:0] txLenBytes = '0;
  logic txReady, txReject;
  logic [15:0] linkTxData;
  logic linkTxValid;
  logic [15:0] linkRxData;
  logic linkRxValid;
  logic [15:0] rxData;
  logic rxValid, rxDone, rxCrcOk, rxLenOk;

  logic loopMode = 1'b0;
  logic [15:0] drvData = '0;
  logic drvValid = 1'b0;

  assign linkRxData  = loopMode ? linkTxData  : drvData;
  assign linkRxValid = loopMode ? linkTxValid : drvValid;

  pktFramerTop dut (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
    .txData(txData), .txLenBytes(txLenBytes), .txReject(txReject),
    .linkTxData(linkTxData), .linkTxValid(linkTxValid),
    .linkRxData(linkRxData), .linkRxValid(linkRxValid),
    .rxData(rxData), .rxValid(rxValid), .rxDone(rxDone),
    .rxCrcOk(rxCrcOk), .rxLenOk(rxLenOk)
  );

  always #4 clk = ~clk;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  logic [15:0] pay [0:63];
  logic [15:0] payCrc;
  logic [15:0] txCap [0:127];
  logic [15:0] rxCap [0:127];
  int txN = 0, rxN = 0, doneN = 0, readyN = 0;
  int txFirst = 0, txLast = 0;
  logic lastCrcOk = 1'b0, lastLenOk = 1'b0;

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++;
      fails++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (linkTxValid) begin
        if (txN == 0) txFirst = cyc;
        txLast = cyc;
        if (txN < 128) txCap[txN] = linkTxData;
        txN++;
      end
      if (txReady) readyN++;
      if (rxValid) begin
        if (rxN < 128) rxCap[rxN] = rxData;
        rxN++;
      end
      if (rxDone) begin
        doneN++;
        lastCrcOk = rxCrcOk;
        lastLenOk = rxLenOk;
      end
    end
  end

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] crcOf(input int nw);
    logic [15:0] r;
    r = 16'hFFFF;
    for (int i = 0; i < nw; i++) begin
      r = crcByte(r, pay[i][15:8]);
      r = crcByte(r, pay[i][7:0]);
    end
    return r;
  endfunction

  task automatic makePayload(input int seed, input int nw);
    for (int i = 0; i < nw; i++) begin
      pay[i] = 16'(seed * 40503 + i * 7919 + 16'h1234);
      if (pay[i] == SOP || pay[i] == EOP) pay[i] = pay[i] ^ 16'h0001;
    end
    payCrc = crcOf(nw);
    while (payCrc == SOP || payCrc == EOP) begin
      pay[0] = pay[0] ^ 16'h0100;
      if (pay[0] == SOP || pay[0] == EOP) pay[0] = pay[0] ^ 16'h0200;
      payCrc = crcOf(nw);
    end
  endtask

  task automatic clearCap();
    txN = 0; rxN = 0; doneN = 0; readyN = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendTx(input int nw, input int gapAt);
    int idx;
    bit fire;
    bit gapDone;
    idx = 0;
    gapDone = 1'b0;
    @(negedge clk);
    txLenBytes = 7'(2 * nw);
    txData = pay[0];
    txValid = 1'b1;
    while (idx < nw) begin
      @(negedge clk);
      fire = txValid && txReady;
      @(posedge clk);
      #1;
      if (fire) idx++;
      if (idx >= nw) begin
        txValid = 1'b0;
      end else begin
        txData = pay[idx];
        if (fire && idx == gapAt && !gapDone) begin
          txValid = 1'b0;
          gapDone = 1'b1;
        end else begin
          txValid = 1'b1;
        end
      end
    end
  endtask

  task automatic pushRx(input logic [15:0] w, input logic v);
    @(negedge clk);
    drvData = w;
    drvValid = v;
  endtask

  task automatic pushFrame(input int nw, input logic [15:0] crcWord);
    pushRx(SOP, 1'b1);
    for (int i = 0; i < nw; i++) pushRx(pay[i], 1'b1);
    pushRx(crcWord, 1'b1);
    pushRx(EOP, 1'b1);
    pushRx(16'h0000, 1'b0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!linkTxValid, "R1 linkTxValid in reset", int'(linkTxValid), 0);
    chk(!txReady, "R1 txReady in reset", int'(txReady), 0);
    chk(!rxValid && !rxDone, "R1 rx outputs in reset", int'({rxValid, rxDone}), 0);
    @(negedge clk);
    rstN = 1'b1;
    idle(3);
    chk(!linkTxValid && !txReady && !rxValid && !rxDone, "R1 quiet after reset",
        int'({linkTxValid, txReady, rxValid, rxDone}), 0);
  endtask

  task automatic testLoop(input int seed, input int nw);
    bit same;
    loopMode = 1'b1;
    makePayload(seed, nw);
    clearCap();
    sendTx(nw, -1);
    idle(6);
    chk(txN == nw + 3, "R2 frame word count", txN, nw + 3);
    chk(txCap[0] == SOP, "R2 start word", int'(txCap[0]), int'(SOP));
    same = 1'b1;
    for (int i = 0; i < nw; i++) if (txCap[i + 1] != pay[i]) same = 1'b0;
    chk(same, "R2 payload order on link", int'(same), 1);
    chk(txCap[nw + 1] == payCrc, "R3 crc word", int'(txCap[nw + 1]), int'(payCrc));
    chk(txCap[nw + 2] == EOP, "R2 end word", int'(txCap[nw + 2]), int'(EOP));
    chk(txLast - txFirst == nw + 2, "R2 frame is contiguous", txLast - txFirst, nw + 2);
    chk(readyN == nw, "R4 ready cycles", readyN, nw);
    chk(rxN == nw, "R7 payload words received", rxN, nw);
    same = 1'b1;
    for (int i = 0; i < nw; i++) if (rxCap[i] != pay[i]) same = 1'b0;
    chk(same, "R7 received payload order", int'(same), 1);
    chk(doneN == 1, "R7 one done pulse", doneN, 1);
    chk(lastCrcOk && lastLenOk, "R8 R9 verdicts on good frame", int'({lastCrcOk, lastLenOk}), 3);
    loopMode = 1'b0;
  endtask

  task automatic testGap();
    bit same;
    loopMode = 1'b1;
    makePayload(77, 6);
    clearCap();
    sendTx(6, 2);
    idle(6);
    chk(txN == 9, "R6 no word lost in pause", txN, 9);
    chk(txLast - txFirst == 9, "R6 pause inserts one empty cycle", txLast - txFirst, 9);
    same = 1'b1;
    for (int i = 0; i < 6; i++) if (txCap[i + 1] != pay[i]) same = 1'b0;
    chk(same, "R6 payload intact", int'(same), 1);
    chk(doneN == 1 && lastCrcOk && lastLenOk, "R6 paused frame checks clean",
        int'({lastCrcOk, lastLenOk}), 3);
    loopMode = 1'b0;
  endtask

  task automatic rejectOne(input int lenBytes);
    clearCap();
    @(negedge clk);
    txLenBytes = 7'(lenBytes);
    txData = 16'h1111;
    txValid = 1'b1;
    #1;
    chk(txReject, "R5 reject raised", int'(txReject), 1);
    chk(!txReady, "R5 ready low on reject", int'(txReady), 0);
    @(posedge clk);
    #1;
    txValid = 1'b0;
    idle(6);
    chk(txN == 0, "R5 nothing on link after reject", txN, 0);
  endtask

  task automatic testReject();
    rejectOne(9);
    rejectOne(6);
    rejectOne(66);
  endtask

  task automatic testRxBad();
    clearCap();
    makePayload(5, 10);
    pushFrame(10, payCrc ^ 16'h0040);
    idle(3);
    chk(doneN == 1, "R8 done on bad crc", doneN, 1);
    chk(!lastCrcOk, "R8 crc mismatch flagged", int'(lastCrcOk), 0);
    chk(lastLenOk, "R9 length fine on bad crc", int'(lastLenOk), 1);
    clearCap();
    makePayload(6, 3);
    pushFrame(3, payCrc);
    idle(3);
    chk(doneN == 1 && !lastLenOk, "R9 short frame flagged", int'(lastLenOk), 0);
    chk(lastCrcOk, "R8 short frame crc fine", int'(lastCrcOk), 1);
    clearCap();
    makePayload(7, 33);
    pushFrame(33, payCrc);
    idle(3);
    chk(doneN == 1 && !lastLenOk, "R9 33-word frame flagged", int'(lastLenOk), 0);
    clearCap();
    makePayload(8, 50);
    pushFrame(50, payCrc);
    idle(3);
    chk(doneN == 1 && !lastLenOk, "R9 50-word frame flagged", int'(lastLenOk), 0);
    chk(lastCrcOk, "R8 long frame crc fine", int'(lastCrcOk), 1);
  endtask

  task automatic testRxHunt();
    bit same;
    clearCap();
    pushRx(16'h1234, 1'b1);
    pushRx(EOP, 1'b1);
    pushRx(16'hABCD, 1'b1);
    pushRx(16'h0000, 1'b0);
    idle(3);
    chk(rxN == 0 && doneN == 0, "R10 words outside frame ignored", rxN + doneN, 0);
    makePayload(9, 5);
    pushRx(SOP, 1'b1);
    pushRx(pay[0], 1'b1);
    pushRx(SOP, 1'b0);
    pushRx(pay[1], 1'b1);
    pushRx(EOP, 1'b0);
    for (int i = 2; i < 5; i++) pushRx(pay[i], 1'b1);
    pushRx(payCrc, 1'b1);
    pushRx(EOP, 1'b1);
    pushRx(16'h0000, 1'b0);
    idle(3);
    chk(rxN == 5, "R10 unqualified words skipped", rxN, 5);
    chk(doneN == 1 && lastCrcOk && lastLenOk, "R10 frame with idle cycles clean",
        int'({lastCrcOk, lastLenOk}), 3);
    clearCap();
    makePayload(11, 4);
    pushRx(SOP, 1'b1);
    pushRx(16'h7777, 1'b1);
    pushRx(16'h8888, 1'b1);
    pushFrame(4, payCrc);
    idle(3);
    chk(doneN == 1, "R10 restart gives one done", doneN, 1);
    chk(lastCrcOk && lastLenOk, "R10 restarted frame clean", int'({lastCrcOk, lastLenOk}), 3);
    same = (rxN == 5);
    for (int i = 0; i < 4; i++) if (same && rxCap[i + 1] != pay[i]) same = 1'b0;
    chk(same, "R10 new frame payload after restart", rxN, 5);
  endtask

  initial begin
    testReset();
    testLoop(1, 4);
    testLoop(2, 20);
    testLoop(3, 32);
    testGap();
    testReject();
    testRxBad();
    testRxHunt();
    summary();
    $finish;
  end

endmodule